// File: doc/BRIEF.md
# External Parallel Bus Access Sequencer

This block turns single requests from on-chip logic into timed read and write cycles on a parallel external bus. Each cycle has three phases, in this order: setup (lead), strobe (active) and hold (trail). Configuration inputs set the length of each phase in timing-clock cycles. The block drives an active-low chip select, a 19-bit address, separate active-low read and write strobes, a direction line, and a 16-bit data path. That data path is split into an output word, an output enable and an input word, so the pad ring can build the bidirectional pins.

The block produces a bus clock. This is either the timing clock itself or a divided copy that runs at half its rate. In half-rate mode every access starts on a rising edge of the bus clock. When a request arrives in the wrong phase, one alignment cycle is inserted first. An optional ready input can stretch the strobe phase. In the synchronous mode it passes through one register, and in the asynchronous mode through two.

The requester presents address, direction and write data and holds them until it sees a one-cycle acknowledge. For reads, the acknowledge comes with the captured data.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, chip select, read strobe and write strobe are high (inactive), the direction line is high (read), the data output enable is low, the acknowledge is low and the address is zero.
- R2: A phase field of value f gives a phase of f timing cycles, and a field of zero gives one cycle. Chip select is low for exactly lead+active+trail consecutive cycles, and the access strobe is low for exactly the active cycles.
- R3: When the doubling input is set, the lead and trail phases are twice their field length (after the zero-to-one rule). The active phase is not doubled.
- R4: In half-rate mode the bus clock toggles on every timing cycle. Chip select always falls in a cycle where the bus clock is high. A request seen while the bus clock is high gets one extra alignment cycle in which chip select and both strobes stay high.
- R5: The address changes only in the cycle chip select falls. Between accesses, including alignment cycles, it holds the last address driven.
- R6: A read drives only the read strobe. Data on the input word is captured at the clock edge that ends the strobe phase, so later changes on the input do not affect it. The captured value appears on the read data output together with the acknowledge.
- R7: A write drives only the write strobe. From the first lead cycle to the last trail cycle, the direction line is low, the output enable is high and the output word equals the request's write data. Outside those cycles the output enable is low.
- R8: With ready enabled in synchronous mode, the strobe phase is checked in its last counted cycle against the ready input registered once. While that value is low, the strobe phase extends one cycle at a time. Ready raised during strobe cycle active+s gives a strobe of active+s+1 cycles.
- R9: In asynchronous ready mode, ready passes through two registers, so the same stimulus gives a strobe of active+s+2 cycles.
- R10: With ready disabled, a ready input held low has no effect, and the strobe lasts exactly the active cycles.
- R11: The acknowledge is a single-cycle pulse in the cycle after the last trail cycle. Counting timing edges from the edge that sees the request, it arrives after alignment+lead+strobe+trail+1 edges. No access starts while the acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLead | input | CNT_W | Lead phase length field |
| cfgActive | input | CNT_W | Active phase length field |
| cfgTrail | input | CNT_W | Trail phase length field |
| cfgDouble | input | 1 | Doubles lead and trail lengths |
| cfgHalfClk | input | 1 | Bus clock at half the timing clock rate |
| cfgReadyEn | input | 1 | Use ready input to stretch the active phase |
| cfgReadyAsync | input | 1 | Asynchronous ready mode (two-stage synchronizer) |
| reqValid | input | 1 | Access request, held until acknowledge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data, valid with acknowledge |
| busClk | output | 1 | Bus clock output |
| busCsN | output | 1 | Zone chip select, active low |
| busAddr | output | ADDR_W | Bus address |
| busRdN | output | 1 | Read strobe, active low |
| busWeN | output | 1 | Write strobe, active low |
| busRnW | output | 1 | Direction, high for read |
| busDout | output | DATA_W | Data driven to the bus |
| busDoe | output | 1 | Data output enable |
| busDin | input | DATA_W | Data sampled from the bus |
| busReady | input | 1 | Ready from the external device |

## Verification
The bench builds the block with its defaults: 4-bit phase fields, a 19-bit address and a 16-bit data word. With these values it reaches zero fields, the largest doubled lead and trail used here, and the full address width in its vector table. It forces both bus-clock phases before half-rate requests, which drives the block through the aligned path and the unaligned path. It also releases ready at chosen strobe cycles in both ready modes, so the stretch length can be predicted exactly.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_LEAD,
    ST_ACTIVE,
    ST_TRAIL
  } ebsState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // latch request at lead entry
    logic captureRd;  // active phase ends this edge
    logic ackSet;     // trail phase ends this edge
    logic csOn;       // an access phase is running
    logic strobeOn;   // active phase is running
  } ebsStrobe_t;

endpackage

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
  import ebs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgLead,
  input  logic [CNT_W-1:0] cfgActive,
  input  logic [CNT_W-1:0] cfgTrail,
  input  logic             cfgDouble,
  input  logic             cfgHalfClk,
  input  logic             cfgReadyEn,
  input  logic             reqValid,
  input  logic             ackBusy,
  input  logic             readySeen,
  output ebsStrobe_t       strobe,
  output logic             clkDiv
);

  localparam int LEN_W = CNT_W + 1;

  function automatic logic [LEN_W-1:0] phaseLen(input logic [CNT_W-1:0] f, input logic dbl);
    logic [LEN_W-1:0] n;
    n = (f == '0) ? LEN_W'(1) : LEN_W'(f);
    return dbl ? (n << 1) : n;
  endfunction

  ebsState_t        state, stateNext;
  logic [LEN_W-1:0] cnt, cntNext;
  logic [LEN_W-1:0] leadLen, actLen, trailLen;

  assign leadLen  = phaseLen(cfgLead, cfgDouble);
  assign actLen   = phaseLen(cfgActive, 1'b0);
  assign trailLen = phaseLen(cfgTrail, cfgDouble);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      ST_IDLE: begin
        if (reqValid && !ackBusy) begin
          if (cfgHalfClk && clkDiv) begin
            stateNext = ST_ALIGN;
          end else begin
            stateNext = ST_LEAD;
            cntNext   = leadLen - LEN_W'(1);
          end
        end
      end
      ST_ALIGN: begin
        stateNext = ST_LEAD;
        cntNext   = leadLen - LEN_W'(1);
      end
      ST_LEAD: begin
        if (cnt == '0) begin
          stateNext = ST_ACTIVE;
          cntNext   = actLen - LEN_W'(1);
        end else begin
          cntNext = cnt - LEN_W'(1);
        end
      end
      ST_ACTIVE: begin
        if (cnt != '0) begin
          cntNext = cnt - LEN_W'(1);
        end else if (!cfgReadyEn || readySeen) begin
          stateNext = ST_TRAIL;
          cntNext   = trailLen - LEN_W'(1);
        end
      end
      ST_TRAIL: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - LEN_W'(1);
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      clkDiv <= 1'b0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      clkDiv <= ~clkDiv;
    end
  end

  always_comb begin
    strobe.loadReq   = (stateNext == ST_LEAD) && (state != ST_LEAD);
    strobe.captureRd = (state == ST_ACTIVE) && (stateNext == ST_TRAIL);
    strobe.ackSet    = (state == ST_TRAIL) && (stateNext == ST_IDLE);
    strobe.csOn      = (state == ST_LEAD) || (state == ST_ACTIVE) || (state == ST_TRAIL);
    strobe.strobeOn  = (state == ST_ACTIVE);
  end

endmodule

// File: rtl/ebs_datapath.sv
module ebs_datapath
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ebsStrobe_t        strobe,
  input  logic              cfgReadyAsync,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busReady,
  output logic              readySeen,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              busCsN,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  output logic              busWeN,
  output logic              busRnW,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoe
);

  logic              wrQ;
  logic              rdyQ1, rdyQ2;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              ackQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ    <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      ackQ   <= 1'b0;
      rdyQ1  <= 1'b1;
      rdyQ2  <= 1'b1;
    end else begin
      rdyQ1 <= busReady;
      rdyQ2 <= rdyQ1;
      ackQ  <= strobe.ackSet;
      if (strobe.loadReq) begin
        wrQ    <= reqWrite;
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.captureRd && !wrQ) rdataQ <= busDin;
    end
  end

  assign readySeen = cfgReadyAsync ? rdyQ2 : rdyQ1;
  assign ack       = ackQ;
  assign rdata     = rdataQ;
  assign busAddr   = addrQ;
  assign busDout   = wdataQ;
  assign busCsN    = ~strobe.csOn;
  assign busRdN    = ~(strobe.strobeOn && !wrQ);
  assign busWeN    = ~(strobe.strobeOn && wrQ);
  assign busRnW    = ~(strobe.csOn && wrQ);
  assign busDoe    = strobe.csOn && wrQ;

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cfgLead,
  input  logic [CNT_W-1:0]  cfgActive,
  input  logic [CNT_W-1:0]  cfgTrail,
  input  logic              cfgDouble,
  input  logic              cfgHalfClk,
  input  logic              cfgReadyEn,
  input  logic              cfgReadyAsync,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              busClk,
  output logic              busCsN,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  output logic              busWeN,
  output logic              busRnW,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoe,
  input  logic [DATA_W-1:0] busDin,
  input  logic              busReady
);

  ebsStrobe_t strobe;
  logic       clkDiv;
  logic       readySeen;

  ebs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgLead(cfgLead), .cfgActive(cfgActive), .cfgTrail(cfgTrail),
    .cfgDouble(cfgDouble), .cfgHalfClk(cfgHalfClk), .cfgReadyEn(cfgReadyEn),
    .reqValid(reqValid), .ackBusy(ack), .readySeen(readySeen),
    .strobe(strobe), .clkDiv(clkDiv)
  );

  ebs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgReadyAsync(cfgReadyAsync),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busDin(busDin), .busReady(busReady), .readySeen(readySeen),
    .ack(ack), .rdata(rdata),
    .busCsN(busCsN), .busAddr(busAddr), .busRdN(busRdN), .busWeN(busWeN),
    .busRnW(busRnW), .busDout(busDout), .busDoe(busDoe)
  );

  assign busClk = cfgHalfClk ? clkDiv : clk;

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgHalfClk,
  input logic              busClk,
  input logic              busCsN,
  input logic              busRdN,
  input logic              busWeN,
  input logic              busRnW,
  input logic              busDoe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              ack
);

  p_rd_in_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> (!busCsN && busWeN));

  p_we_in_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busWeN |-> (!busCsN && !busRnW));

  p_doe_dir_r7: assert property (@(posedge clk) disable iff (!rstN)
    busDoe |-> (!busRnW && !busCsN));

  p_lead_on_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgHalfClk && $fell(busCsN)) |-> busClk);

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(busCsN) |-> $stable(busAddr));

  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  p_ack_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> busCsN);

endmodule

bind ext_bus_seq ebs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgHalfClk(cfgHalfClk), .busClk(busClk),
  .busCsN(busCsN), .busRdN(busRdN), .busWeN(busWeN), .busRnW(busRnW),
  .busDoe(busDoe), .busAddr(busAddr), .ack(ack)
);

// File: tb/ext_bus_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_seq_tb;

  localparam int CNT_W = 4, ADDR_W = 19, DATA_W = 16;

  typedef struct packed {
    logic        half, dbl;
    logic [3:0]  lead, act, trail;
    logic        wr, rdyEn, rdyAsync, rdyLow;
    logic [3:0]  stretch;
    logic [18:0] addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,4'd1,4'd3,4'd1,1'b0,1'b0,1'b0,1'b0,4'd0,19'h12345,16'hA5C3},
    '{1'b0,1'b0,4'd1,4'd3,4'd1,1'b0,1'b1,1'b0,1'b1,4'd2,19'h00F0F,16'h1357},
    '{1'b0,1'b0,4'd1,4'd3,4'd1,1'b0,1'b1,1'b1,1'b1,4'd1,19'h7FFFF,16'hBEEF},
    '{1'b0,1'b0,4'd2,4'd2,4'd3,1'b1,1'b0,1'b0,1'b0,4'd0,19'h40001,16'h6C6C},
    '{1'b1,1'b0,4'd1,4'd3,4'd1,1'b0,1'b0,1'b0,1'b0,4'd0,19'h2AAAA,16'h0FF0},
    '{1'b1,1'b1,4'd2,4'd1,4'd2,1'b1,1'b0,1'b0,1'b0,4'd0,19'h15555,16'hF00D},
    '{1'b0,1'b0,4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,1'b0,4'd0,19'h00003,16'h8001},
    '{1'b0,1'b0,4'd1,4'd2,4'd1,1'b1,1'b0,1'b0,1'b1,4'd0,19'h33333,16'h4242},
    '{1'b1,1'b1,4'd3,4'd4,4'd2,1'b0,1'b1,1'b1,1'b1,4'd0,19'h0ABCD,16'hC0DE}
  };

  logic              clk = 1'b0, rstN = 1'b0;
  logic [CNT_W-1:0]  cfgLead = '0, cfgActive = '0, cfgTrail = '0;
  logic              cfgDouble = 0, cfgHalfClk = 0, cfgReadyEn = 0, cfgReadyAsync = 0;
  logic              reqValid = 0, reqWrite = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0, busDin = '0;
  logic              busReady = 1'b1;
  logic              ack, busClk, busCsN, busRdN, busWeN, busRnW, busDoe;
  logic [DATA_W-1:0] rdata, busDout;
  logic [ADDR_W-1:0] busAddr;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ext_bus_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgLead(cfgLead), .cfgActive(cfgActive), .cfgTrail(cfgTrail),
    .cfgDouble(cfgDouble), .cfgHalfClk(cfgHalfClk), .cfgReadyEn(cfgReadyEn),
    .cfgReadyAsync(cfgReadyAsync), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ack(ack), .rdata(rdata), .busClk(busClk),
    .busCsN(busCsN), .busAddr(busAddr), .busRdN(busRdN), .busWeN(busWeN),
    .busRnW(busRnW), .busDout(busDout), .busDoe(busDoe), .busDin(busDin), .busReady(busReady)
  );

  task automatic check(input bit ok, input string req, input string what, input int actV, input int expV);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actV, expV);
    end
  endtask

  function automatic int effLen(input logic [3:0] f, input logic d);
    int n;
    n = (f == 0) ? 1 : int'(f);
    return d ? 2 * n : n;
  endfunction

  task automatic runAccess(input vec_t v, input int phaseWant, output bit aligned);
    int k, csLow, stbLow, othLow, doeCnt, badW, stbExp, csExp;
    bit firstCs, leadRise, seenAck, stb, oth;
    cfgLead = v.lead; cfgActive = v.act; cfgTrail = v.trail; cfgDouble = v.dbl;
    cfgHalfClk = v.half; cfgReadyEn = v.rdyEn; cfgReadyAsync = v.rdyAsync;
    @(negedge clk);
    if (phaseWant >= 0) while (busClk !== phaseWant[0]) @(negedge clk);
    reqWrite = v.wr; reqAddr = v.addr; reqWdata = v.data; busDin = v.data;
    busReady = v.rdyLow ? 1'b0 : 1'b1;
    reqValid = 1'b1;
    aligned = v.half && (busClk === 1'b1);
    k = 0; csLow = 0; stbLow = 0; othLow = 0; doeCnt = 0; badW = 0;
    firstCs = 1; leadRise = 1; seenAck = 0;
    while (!seenAck && k < 200) begin
      @(negedge clk);
      k++;
      if (!busCsN) begin
        csLow++;
        if (firstCs) begin
          firstCs = 0;
          if (v.half && busClk !== 1'b1) leadRise = 0;
        end
      end
      stb = v.wr ? !busWeN : !busRdN;
      oth = v.wr ? !busRdN : !busWeN;
      if (stb) stbLow++;
      if (oth) othLow++;
      if (!stb && stbLow > 0 && !v.wr) busDin = ~v.data;
      if (busDoe) begin
        doeCnt++;
        if (busDout !== v.data || busRnW !== 1'b0) badW++;
      end
      if (v.rdyLow && stb && stbLow == int'(v.act) + int'(v.stretch)) busReady = 1'b1;
      if (ack) seenAck = 1;
    end
    if (v.rdyEn && v.rdyLow) stbExp = effLen(v.act, 1'b0) + int'(v.stretch) + 1 + int'(v.rdyAsync);
    else stbExp = effLen(v.act, 1'b0);
    csExp = effLen(v.lead, v.dbl) + stbExp + effLen(v.trail, v.dbl);
    // R2 R3 R8 R9 R10: strobe and select lengths
    check(stbLow == stbExp, v.rdyEn ? (v.rdyAsync ? "R9" : "R8") : (v.rdyLow ? "R10" : "R2"),
          "strobe cycles", stbLow, stbExp);
    check(csLow == csExp, v.dbl ? "R3" : "R2", "select cycles", csLow, csExp);
    check(othLow == 0, v.wr ? "R7" : "R6", "wrong strobe cycles", othLow, 0);
    // R11: acknowledge latency
    check(k == int'(aligned) + csExp + 1, "R11", "ack latency", k, int'(aligned) + csExp + 1);
    if (v.half) check(leadRise, "R4", "select fell with bus clock high", leadRise, 1);
    check(busAddr === v.addr, "R5", "address at ack", busAddr, v.addr);
    if (v.wr) begin
      check(doeCnt == csExp && badW == 0, "R7", "write drive cycles", doeCnt, csExp);
    end else begin
      check(rdata === v.data, "R6", "read data", rdata, v.data);
      check(doeCnt == 0, "R6", "enable during read", doeCnt, 0);
    end
    reqValid = 1'b0;
    busReady = 1'b1;
    @(negedge clk);
    check(ack === 1'b0, "R11", "ack width", ack, 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit al;
    vec_t v;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busCsN === 1 && busRdN === 1 && busWeN === 1, "R1", "strobes in reset",
          {busCsN, busRdN, busWeN}, 7);
    check(busRnW === 1 && busDoe === 0 && ack === 0 && busAddr === '0, "R1", "dir/enable/addr in reset",
          {busRnW, busDoe, ack}, 4);
    rstN = 1'b1;
    @(negedge clk);
    check(busCsN === 1 && busDoe === 0 && ack === 0, "R1", "state after reset", {busCsN, busDoe, ack}, 4);

    for (int i = 0; i < NV; i++) begin
      runAccess(VECS[i], -1, al);
    end

    // R5: address held while idle
    repeat (3) @(negedge clk);
    check(busAddr === VECS[NV-1].addr && busCsN === 1, "R5", "idle address hold", busAddr, VECS[NV-1].addr);

    // R4: half-rate bus clock toggles every timing cycle
    cfgHalfClk = 1'b1;
    begin
      logic prev;
      int toggles;
      toggles = 0;
      @(negedge clk);
      prev = busClk;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (busClk !== prev) toggles++;
        prev = busClk;
      end
      check(toggles == 4, "R4", "bus clock toggles", toggles, 4);
    end

    // R4: forced alignment and forced no alignment
    v = VECS[4];
    runAccess(v, 1, al);
    check(al == 1, "R4", "aligned request path", al, 1);
    v.addr = 19'h01234; v.data = 16'h5AA5;
    runAccess(v, 0, al);
    check(al == 0, "R4", "unaligned-free request path", al, 0);
    v.wr = 1'b1; v.addr = 19'h6EDCB;
    runAccess(v, 1, al);
    check(al == 1, "R4", "aligned write path", al, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule